// File: doc/BRIEF.md
# Selectable-Source Two-Stage Peripheral Clock Divider

This block derives one peripheral clock from a choice of four source clocks. Each source arrives as a single-cycle tick in the system clock domain, so the whole block is one synchronous design. A select field chooses the source. Two cascaded integer factors then set the division, and the total division is their product. An active-high disable bit gates the result. The output is a tick stream with one pulse per completed output period. When the total division is one, every selected source tick passes through.

A small register port holds the select field, the two factor fields and the disable bit. Two read-only locations report the total division of the written fields and an error flag for the configuration in use. A factor of zero or seven is invalid. Any invalid factor makes the total zero, holds the output quiet and raises the error flag.

New settings never cut an output period short. The configuration in use is reloaded only when no period is in progress, that is, when the period counter stands at zero. The block has no data stream. The register port completes every write in one cycle and the output tick cannot be stalled, so no back-pressure exists anywhere.

Top module: `pclk_divgen`

## Requirements
- R1: After reset the written fields read select 0, first factor 1, second factor 1 and disable 1, the total reads 1, the error flag is 0, and no output tick appears while the disable bit stays 1.
- R2: Only ticks of the source whose index equals the select field (address 0, bits [1:0]) advance the divider. Ticks on any other source have no effect on the output.
- R3: With valid factors A (address 1, bits [2:0]) and B (address 2, bits [2:0]), exactly one output tick is produced per A*B selected ticks. It appears one clock after the selected tick that completes the period.
- R4: A factor of 0 or 7 is invalid. The total then reads 0, the error flag (address 5, bit 0) reads 1 once the setting is in use, and no output tick is produced.
- R5: While the disable bit (address 3, bit 0) is 1 in the configuration in use, no output tick is produced. Writing 0 resumes division.
- R6: A write made while a period is in progress does not change that period. The new configuration governs from the next period on.
- R7: With a total of 1, every selected source tick yields an output tick one clock later.
- R8: The total at address 4 equals the product of the written factors, visible in the cycle after the write. Writes to address 4 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_tick | input | 4 | One tick per edge of each source clock |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for read and write |
| wdata | input | 3 | Write data |
| rd_data | output | 6 | Combinational read data for addr |
| out_tick | output | 1 | Divided, gated output tick |
| err | output | 1 | Configuration in use has an invalid factor |

## Verification
A selected source tick presented before a clock edge is counted at that edge. Any output tick it causes is registered at the same edge. The bench therefore drives each tick for one cycle and samples out_tick at the following falling edge. A write lands in the fields at one edge, and read data settles combinationally right after it. The error flag follows one edge later, once the configuration is in use, so the bench leaves one idle cycle before checking it. Output periods are checked as bit masks over a run of ticks. Each mask position is the tick index at which a pulse must appear.

// File: rtl/pclk_pkg.sv
package pclk_pkg;
  localparam int SRC_N   = 4;
  localparam int SEL_W   = $clog2(SRC_N);
  localparam int FIELD_W = 3;
  localparam int FIELD_MAX = 6;
  localparam int TOT_W   = 2 * FIELD_W;
  localparam int ADDR_W  = 3;

  typedef struct packed {
    logic [SEL_W-1:0]   sel;
    logic [FIELD_W-1:0] fa;
    logic [FIELD_W-1:0] fb;
    logic               off;
  } pclk_cfg_t;

  localparam int CFG_W = $bits(pclk_cfg_t);

  // Valid factor keeps its value; an out-of-range factor counts as zero.
  function automatic logic [TOT_W-1:0] factor_val(input logic [FIELD_W-1:0] f);
    if (int'(f) > FIELD_MAX) return '0;
    return {{(TOT_W-FIELD_W){1'b0}}, f};
  endfunction

  function automatic logic [TOT_W-1:0] total_div(input pclk_cfg_t c);
    return factor_val(c.fa) * factor_val(c.fb);
  endfunction
endpackage

// File: rtl/pclk_regs.sv
module pclk_regs
  import pclk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [FIELD_W-1:0] wdata,
  input  logic              err,
  output pclk_cfg_t         shadow,
  output logic [TOT_W-1:0]  rd_data
);
  localparam logic [ADDR_W-1:0] A_SEL = 3'd0;
  localparam logic [ADDR_W-1:0] A_FA  = 3'd1;
  localparam logic [ADDR_W-1:0] A_FB  = 3'd2;
  localparam logic [ADDR_W-1:0] A_OFF = 3'd3;
  localparam logic [ADDR_W-1:0] A_TOT = 3'd4;
  localparam logic [ADDR_W-1:0] A_ERR = 3'd5;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow.sel <= '0;
      shadow.fa  <= FIELD_W'(1);
      shadow.fb  <= FIELD_W'(1);
      shadow.off <= 1'b1;
    end else if (wr_en) begin
      case (addr)
        A_SEL:   shadow.sel <= wdata[SEL_W-1:0];
        A_FA:    shadow.fa  <= wdata;
        A_FB:    shadow.fb  <= wdata;
        A_OFF:   shadow.off <= wdata[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_data = '0;
    case (addr)
      A_SEL:   rd_data[SEL_W-1:0]   = shadow.sel;
      A_FA:    rd_data[FIELD_W-1:0] = shadow.fa;
      A_FB:    rd_data[FIELD_W-1:0] = shadow.fb;
      A_OFF:   rd_data[0]           = shadow.off;
      A_TOT:   rd_data              = total_div(shadow);
      A_ERR:   rd_data[0]           = err;
      default: rd_data              = '0;
    endcase
  end
endmodule

// File: rtl/pclk_core.sv
module pclk_core
  import pclk_pkg::*;
#(
  parameter int NSRC = SRC_N
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_tick,
  input  pclk_cfg_t       shadow,
  output pclk_cfg_t       act,
  output logic [TOT_W-1:0] act_total,
  output logic [TOT_W-1:0] cnt,
  output logic            out_tick
);
  pclk_cfg_t        eff;
  logic [TOT_W-1:0] eff_total;
  logic [NSRC-1:0]  hit;
  logic             tick;
  logic             run;

  // Reload only between periods so a running period keeps its length.
  assign eff       = (cnt == '0) ? shadow : act;
  assign eff_total = total_div(eff);
  assign act_total = total_div(act);
  assign run       = !eff.off && (eff_total != '0);

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign hit[g] = src_tick[g] && (eff.sel == SEL_W'(g));
  end
  assign tick = |hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act.sel  <= '0;
      act.fa   <= FIELD_W'(1);
      act.fb   <= FIELD_W'(1);
      act.off  <= 1'b1;
      cnt      <= '0;
      out_tick <= 1'b0;
    end else begin
      act <= eff;
      if (!run) begin
        cnt      <= '0;
        out_tick <= 1'b0;
      end else if (tick) begin
        if (cnt == eff_total - TOT_W'(1)) begin
          cnt      <= '0;
          out_tick <= 1'b1;
        end else begin
          cnt      <= cnt + TOT_W'(1);
          out_tick <= 1'b0;
        end
      end else begin
        out_tick <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pclk_divgen.sv
module pclk_divgen
  import pclk_pkg::*;
#(
  parameter int NSRC = SRC_N
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NSRC-1:0]    src_tick,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [FIELD_W-1:0] wdata,
  output logic [TOT_W-1:0]   rd_data,
  output logic               out_tick,
  output logic               err
);
  pclk_cfg_t        shadow;
  pclk_cfg_t        act;
  logic [TOT_W-1:0] act_total;
  logic [TOT_W-1:0] cnt;

  assign err = (act_total == '0);

  pclk_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .err     (err),
    .shadow  (shadow),
    .rd_data (rd_data)
  );

  pclk_core #(.NSRC(NSRC)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_tick  (src_tick),
    .shadow    (shadow),
    .act       (act),
    .act_total (act_total),
    .cnt       (cnt),
    .out_tick  (out_tick)
  );
endmodule

// File: rtl/pclk_divgen_chk.sv
module pclk_divgen_chk
  import pclk_pkg::*;
#(
  parameter int NSRC = SRC_N
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NSRC-1:0]  src_tick,
  input logic             out_tick,
  input logic             err,
  input logic             act_off,
  input logic [TOT_W-1:0] act_total,
  input logic [TOT_W-1:0] cnt,
  input logic [CFG_W-1:0] act_bits
);
  // R4: an invalid configuration in use never lets a tick out
  assert_invalid_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !out_tick);

  // R5: a disabled configuration in use never lets a tick out
  assert_gated_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    act_off |-> !out_tick);

  // R3: the period counter stays inside the period in use
  assert_cnt_in_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (act_total != '0) |-> (cnt < act_total));

  // R4: an invalid total keeps the counter parked
  assert_cnt_parked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (act_total == '0) |-> (cnt == '0));

  // R6: configuration in use is frozen while a period runs
  assert_cfg_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |=> $stable(act_bits));

  // R2: an output tick needs a source tick on the previous cycle
  assert_tick_caused_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_tick |-> $past(|src_tick));
endmodule

bind pclk_divgen pclk_divgen_chk #(.NSRC(NSRC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .src_tick  (src_tick),
  .out_tick  (out_tick),
  .err       (err),
  .act_off   (act.off),
  .act_total (act_total),
  .cnt       (cnt),
  .act_bits  (act)
);

// File: tb/test_pclk_divgen.sv
module test_pclk_divgen;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] src_tick = '0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [2:0] wdata = '0;
  logic [5:0] rd_data;
  logic       out_tick;
  logic       err;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pclk_divgen #(.NSRC(NSRC)) i_pclk_divgen (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rd_data(rd_data), .out_tick(out_tick), .err(err)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic reg_write(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; addr = 3'(a); wdata = 3'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_read(input int a, output int v);
    @(negedge clk);
    addr = 3'(a);
    #1 v = int'(rd_data);
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic tick_one(input int idx, output bit p);
    @(negedge clk);
    src_tick = 4'(1 << idx);
    @(negedge clk);
    src_tick = '0;
    p = out_tick;
  endtask

  task automatic tick_run(input int idx, input int n, output int mask);
    bit p;
    mask = 0;
    for (int i = 0; i < n; i++) begin
      tick_one(idx, p);
      if (p) mask |= (1 << i);
    end
  endtask

  task automatic t_reset();
    int v, m;
    reg_read(0, v); check("R1", "select", v, 0);
    reg_read(1, v); check("R1", "factor A", v, 1);
    reg_read(2, v); check("R1", "factor B", v, 1);
    reg_read(3, v); check("R1", "disable", v, 1);
    reg_read(4, v); check("R1", "total", v, 1);
    check("R1", "err", int'(err), 0);
    tick_run(0, 4, m); check("R1", "gated pulses", m, 0);
  endtask

  task automatic t_passthrough();
    int m;
    reg_write(3, 0);
    tick_run(0, 3, m); check("R7", "div1 pulses", m, 'b111);
    tick_run(1, 3, m); check("R2", "unselected src1", m, 0);
  endtask

  task automatic t_product();
    int v, m;
    bit p;
    reg_write(0, 2); reg_write(1, 2); reg_write(2, 3);
    reg_read(4, v); check("R8", "total 2*3", v, 6);
    m = 0;
    for (int i = 0; i < 12; i++) begin
      tick_one(2, p); if (p) m |= (1 << i);
      tick_one(0, p); if (p) check("R2", "src0 pulse while sel 2", 1, 0);
    end
    check("R3", "div6 pulse mask", m, 'h820);
    reg_write(0, 3);
    tick_run(2, 6, m); check("R2", "src2 after sel 3", m, 0);
    reg_write(0, 2);
  endtask

  task automatic t_midperiod();
    int v, m;
    tick_run(2, 2, m); check("R6", "first ticks", m, 0);
    reg_write(1, 1); reg_write(2, 1);
    reg_read(4, v); check("R8", "total after rewrite", v, 1);
    tick_run(2, 4, m); check("R6", "old period kept", m, 'b1000);
    tick_run(2, 3, m); check("R6", "new period used", m, 'b111);
  endtask

  task automatic t_invalid();
    int v, m;
    reg_write(1, 7); idle();
    reg_read(4, v); check("R4", "total with 7", v, 0);
    check("R4", "err with 7", int'(err), 1);
    reg_read(5, v); check("R4", "err reg with 7", v, 1);
    tick_run(2, 4, m); check("R4", "pulses with 7", m, 0);
    reg_write(1, 0); idle();
    reg_read(4, v); check("R4", "total with 0", v, 0);
    check("R4", "err with 0", int'(err), 1);
    tick_run(2, 3, m); check("R4", "pulses with 0", m, 0);
    reg_write(1, 2); idle();
    check("R4", "err cleared", int'(err), 0);
    tick_run(2, 4, m); check("R3", "div2 mask", m, 'b1010);
  endtask

  task automatic t_gate_and_ro();
    int v, m;
    reg_write(3, 1);
    tick_run(2, 4, m); check("R5", "disabled pulses", m, 0);
    reg_write(4, 7);
    reg_read(1, v); check("R8", "factor A after ro write", v, 2);
    reg_read(2, v); check("R8", "factor B after ro write", v, 1);
    reg_read(4, v); check("R8", "total after ro write", v, 2);
    reg_write(3, 0);
    tick_run(2, 4, m); check("R5", "re-enabled mask", m, 'b1010);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_passthrough();
    t_product();
    t_midperiod();
    t_invalid();
    t_gate_and_ro();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule